// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit Codec

This block is the bit-level layer of a single-wire, open-drain bus on which each symbol is carried by how long the line stays low. There are three symbol classes: a short sync pulse, a medium zero pulse and a long one pulse. The encoder turns one accepted symbol into a low pulse on the open-drain drive enable. The decoder watches the synchronized line and classifies every low pulse it sees, including the node's own pulses. The time base is a parameter `UNIT_CYC`, the number of clock cycles per time unit. It must be at least 4.

A node acting as bus master sends a symbol by holding the line low for the symbol's length. It then releases the line for the rest of an 8-unit bit slot. To read a bit from a slave, the master sends a sync symbol. A node acting as slave arms a symbol in advance. When it sees the master's falling edge, it joins the low pulse before the sync time runs out and holds the line low until its own symbol length is reached. The decoder then reports the length of the combined pulse.

Top module: `pwm_bit_codec`

## Requirements
- R1: While `rst_ni` is low, `drive_low_o` is 0, `tx_ready_o` is 1 and `rx_valid_o` is 0.
- R2: Symbol codes on `tx_sym_i` and `rx_sym_o` are 0 = sync (1 unit), 1 = zero (3 units) and 2 = one (6 units). `rx_sym_o` = 3 marks an invalid pulse. A symbol is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both 1.
- R3: With `role_slave_i` = 0, `drive_low_o` is 1 from the cycle after acceptance for exactly units × `UNIT_CYC` cycles.
- R4: With `role_slave_i` = 0, `tx_ready_o` stays 0 for exactly 8 × `UNIT_CYC` cycles after acceptance, which is one full bit slot.
- R5: With `role_slave_i` = 1, an accepted symbol produces no drive until the line falls. `drive_low_o` then rises at the third rising clock edge after the line is first low at a clock edge. It stays 1 for units × `UNIT_CYC` cycles, after which `tx_ready_o` returns to 1.
- R6: With `role_slave_i` = 1 and no symbol accepted, `drive_low_o` stays 0 while other nodes pulse the line.
- R7: The decoder counts L, the number of clock edges at which the synchronized line is low during one pulse. It reports sync for L < 2U, zero for 2U ≤ L < 5U and one for 5U ≤ L < 8U, where U = `UNIT_CYC`.
- R8: A pulse with L ≥ 8U is reported as code 3.
- R9: Each low pulse gives exactly one `rx_valid_o` pulse, one cycle wide, after the line returns high.
- R10: In a slave-transmit bit, the master's sync pulse and the slave's extension decode as the slave's symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| role_slave_i | input | 1 | 0 = master sends pulses itself, 1 = slave extends master's pulse |
| tx_valid_i | input | 1 | Symbol to send is valid |
| tx_sym_i | input | 2 | Symbol code to send |
| tx_ready_o | output | 1 | Encoder idle, able to accept a symbol |
| line_i | input | 1 | Raw bus line level (asynchronous) |
| drive_low_o | output | 1 | Open-drain enable: 1 pulls the line low |
| rx_valid_o | output | 1 | One-cycle strobe: a pulse was classified |
| rx_sym_o | output | 2 | Classified symbol code, 3 = invalid |

## Verification
The assertions assume three things about the inputs. `tx_sym_i` stays stable while a symbol waits for acceptance. `role_slave_i` does not change while the encoder is busy. In slave role, the master keeps its sync pulse low long enough for the slave's delayed takeover, which `UNIT_CYC` ≥ 4 guarantees. The stimulus offers a symbol only while `tx_ready_o` is high and holds it for a single cycle. It changes the role only between bits. It models the other node as a separate pull-down that is ANDed onto the line, with pulse lengths placed on both sides of every classification boundary.

// File: rtl/pwm_codec_pkg.sv
package pwm_codec_pkg;
  typedef enum logic [1:0] {
    SYM_SYNC = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2,
    SYM_BAD  = 2'd3
  } sym_e;

  localparam int unsigned SLOT_UNITS    = 8;
  localparam int unsigned LEN_SYNC      = 1;
  localparam int unsigned LEN_ZERO      = 3;
  localparam int unsigned LEN_ONE       = 6;
  localparam int unsigned ZERO_MIN_UNIT = 2;
  localparam int unsigned ONE_MIN_UNIT  = 5;

  function automatic int unsigned sym_units(logic [1:0] s);
    case (s)
      SYM_ZERO: return LEN_ZERO;
      SYM_ONE:  return LEN_ONE;
      default:  return LEN_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/pwm_line_sync.sv
module pwm_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_s_o = sync_q[STAGES-1];
  assign rise_o   = ~prev_q & line_s_o;
  assign fall_o   = prev_q & ~line_s_o;
endmodule

// File: rtl/pwm_tx.sv
module pwm_tx
  import pwm_codec_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 4,
  parameter int unsigned CW       = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       role_slave_i,
  input  logic       tx_valid_i,
  input  logic [1:0] tx_sym_i,
  input  logic       fall_i,
  output logic       tx_ready_o,
  output logic       drive_low_o
);
  localparam logic [CW-1:0] SLOT_CYC = CW'(SLOT_UNITS * UNIT_CYC);
  localparam logic [CW-1:0] ONE_C    = CW'(1);

  typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_LOW, TX_GAP} tx_state_e;

  tx_state_e     state_q;
  logic [CW-1:0] len_q, cnt_q, tx_len;
  logic          role_q;

  assign tx_len = CW'(sym_units(tx_sym_i) * UNIT_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      role_q  <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: if (tx_valid_i) begin
          len_q   <= tx_len;
          role_q  <= role_slave_i;
          cnt_q   <= '0;
          state_q <= role_slave_i ? TX_ARM : TX_LOW;
        end
        TX_ARM: if (fall_i) begin
          cnt_q   <= '0;
          state_q <= TX_LOW;
        end
        TX_LOW: begin
          if (cnt_q == len_q - ONE_C) begin
            cnt_q   <= '0;
            state_q <= role_q ? TX_IDLE : TX_GAP;
          end else begin
            cnt_q <= cnt_q + ONE_C;
          end
        end
        default: begin
          // release for the remainder of the bit slot
          if (cnt_q == SLOT_CYC - len_q - ONE_C) state_q <= TX_IDLE;
          else                                   cnt_q   <= cnt_q + ONE_C;
        end
      endcase
    end
  end

  assign tx_ready_o  = (state_q == TX_IDLE);
  assign drive_low_o = (state_q == TX_LOW);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !drive_low_o); // R6
  AST_SLAVE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drive_low_o) && role_q) |-> $past(fall_i)); // R5
  AST_LEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_ready_o && $past(!tx_ready_o)) |-> $stable(len_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < SLOT_CYC); // R4
endmodule

// File: rtl/pwm_rx.sv
module pwm_rx
  import pwm_codec_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 4,
  parameter int unsigned CW       = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_s_i,
  input  logic       rise_i,
  output logic       rx_valid_o,
  output logic [1:0] rx_sym_o
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(SLOT_UNITS * UNIT_CYC);
  localparam logic [CW-1:0] ZERO_MIN = CW'(ZERO_MIN_UNIT * UNIT_CYC);
  localparam logic [CW-1:0] ONE_MIN  = CW'(ONE_MIN_UNIT * UNIT_CYC);

  logic [CW-1:0] cnt_q;
  logic          valid_q;
  sym_e          sym_q, sym_d;

  always_comb begin
    if      (cnt_q < ZERO_MIN) sym_d = SYM_SYNC;
    else if (cnt_q < ONE_MIN)  sym_d = SYM_ZERO;
    else if (cnt_q < CNT_MAX)  sym_d = SYM_ONE;
    else                       sym_d = SYM_BAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      sym_q   <= SYM_SYNC;
    end else begin
      if (!line_s_i) cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
      else           cnt_q <= '0;
      valid_q <= rise_i;
      if (rise_i) sym_q <= sym_d;
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_sym_o   = sym_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R8
  AST_BAD_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && sym_q == SYM_BAD) |-> ($past(cnt_q) == CNT_MAX)); // R8
endmodule

// File: rtl/pwm_bit_codec.sv
module pwm_bit_codec
  import pwm_codec_pkg::*;
#(
  parameter int unsigned UNIT_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       role_slave_i,
  input  logic       tx_valid_i,
  input  logic [1:0] tx_sym_i,
  output logic       tx_ready_o,
  input  logic       line_i,
  output logic       drive_low_o,
  output logic       rx_valid_o,
  output logic [1:0] rx_sym_o
);
  localparam int unsigned CW = $clog2(SLOT_UNITS * UNIT_CYC + 1);

  logic line_s, line_rise, line_fall;

  pwm_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .line_s_o (line_s),
    .rise_o   (line_rise),
    .fall_o   (line_fall)
  );

  pwm_tx #(.UNIT_CYC(UNIT_CYC), .CW(CW)) i_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_slave_i (role_slave_i),
    .tx_valid_i   (tx_valid_i),
    .tx_sym_i     (tx_sym_i),
    .fall_i       (line_fall),
    .tx_ready_o   (tx_ready_o),
    .drive_low_o  (drive_low_o)
  );

  pwm_rx #(.UNIT_CYC(UNIT_CYC), .CW(CW)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_s_i   (line_s),
    .rise_i     (line_rise),
    .rx_valid_o (rx_valid_o),
    .rx_sym_o   (rx_sym_o)
  );

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_o) |=> (tx_valid_i && $stable(tx_sym_i))); // R2
  AST_ROLE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_o |-> $stable(role_slave_i)); // R5
endmodule

// File: tb/test_pwm_bit_codec.sv
`timescale 1ns/1ps
module test_pwm_bit_codec;
  localparam int U = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       role_slave = 1'b0;
  logic       tx_valid = 1'b0;
  logic [1:0] tx_sym = 2'd0;
  logic       tx_ready, drive_low, rx_valid;
  logic [1:0] rx_sym;
  logic       peer_low = 1'b0;
  logic       line;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;
  assign line = ~(drive_low | peer_low);

  pwm_bit_codec #(.UNIT_CYC(U)) i_pwm_bit_codec (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .role_slave_i (role_slave),
    .tx_valid_i   (tx_valid),
    .tx_sym_i     (tx_sym),
    .tx_ready_o   (tx_ready),
    .line_i       (line),
    .drive_low_o  (drive_low),
    .rx_valid_o   (rx_valid),
    .rx_sym_o     (rx_sym)
  );

  // peer pulse length in cycles and expected decode (U = 4)
  localparam int NVEC = 11;
  localparam int VEC_LEN [NVEC] = '{1, 4, 7, 8, 12, 19, 20, 24, 31, 32, 40};
  localparam int VEC_SYM [NVEC] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 3, 3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int n_drive, first_drive, n_rx, last_sym, n_busy;

  task automatic run_window(input int peer_n, input int win);
    n_drive = 0; first_drive = -1; n_rx = 0; last_sym = -1; n_busy = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (drive_low) begin
        n_drive++;
        if (first_drive < 0) first_drive = i;
      end
      if (rx_valid) begin
        n_rx++;
        last_sym = int'(rx_sym);
      end
      if (!tx_ready) n_busy++;
      tx_valid = 1'b0;
      peer_low = (i < peer_n);
    end
    peer_low = 1'b0;
  endtask

  task automatic offer(input logic [1:0] s);
    @(negedge clk);
    tx_sym   = s;
    tx_valid = 1'b1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drive_low == 1'b0, "R1 drive in reset", int'(drive_low), 0);
    check(tx_ready == 1'b1, "R1 ready in reset", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R1 rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // decoder thresholds driven by the peer alone
    for (int v = 0; v < NVEC; v++) begin
      run_window(VEC_LEN[v], 60);
      check(n_rx == 1, "R9 one strobe per pulse", n_rx, 1);
      check(last_sym == VEC_SYM[v], (VEC_SYM[v] == 3) ? "R8 long pulse" : "R7 classify",
            last_sym, VEC_SYM[v]);
    end

    // master transmit, with loopback decode
    for (int s = 0; s < 3; s++) begin
      int units;
      units = (s == 0) ? 1 : (s == 1) ? 3 : 6;
      offer(2'(s));
      run_window(0, 50);
      check(n_drive == units * U, "R3 master drive length", n_drive, units * U);
      check(first_drive == 0, "R3 drive starts after accept", first_drive, 0);
      check(n_busy == 8 * U, "R4 slot length", n_busy, 8 * U);
      check(last_sym == s, "R2 loopback code", last_sym, s);
    end

    // slave role, nothing armed
    role_slave = 1'b1;
    run_window(U, 40);
    check(n_drive == 0, "R6 unarmed slave silent", n_drive, 0);
    check(last_sym == 0, "R6 master sync decoded", last_sym, 0);

    // slave transmit zero and one
    for (int s = 1; s < 3; s++) begin
      int units;
      units = (s == 1) ? 3 : 6;
      offer(2'(s));
      run_window(0, 10);
      check(n_drive == 0, "R5 armed slave waits for edge", n_drive, 0);
      check(tx_ready == 1'b0, "R5 armed slave busy", int'(tx_ready), 0);
      run_window(U, 60);
      check(first_drive == 3, "R5 takeover delay", first_drive, 3);
      check(n_drive == units * U, "R5 slave drive length", n_drive, units * U);
      check(tx_ready == 1'b1, "R5 ready after bit", int'(tx_ready), 1);
      check(last_sym == s, "R10 slave bit decoded", last_sym, s);
    end
    role_slave = 1'b0;

    // reset mid-transmission
    offer(2'd2);
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(drive_low == 1'b0, "R1 drive after async reset", int'(drive_low), 0);
    check(tx_ready == 1'b1, "R1 ready after async reset", int'(tx_ready), 1);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    summary();
    $finish;
  end
endmodule